// File: doc/BRIEF.md
# Two-Level Interrupt Controller with Event Log

This block sits beside a serial-bus protocol engine and turns the engine's one-cycle event pulses into host interrupts. Eight protocol events feed a high-priority path. Each has a status bit that the host clears by writing ones, and the path raises a level interrupt whenever a pending status bit is also enabled. A second, standard-priority path watches six further event flags. Each qualifying standard event raises a level output, which the host acknowledges through bit 0 of the high-priority status. Each such event is also appended to a history list in system memory.

The history list is written through a simple request/acknowledge write port. Every entry takes two consecutive words at the address held in an auto-advancing list pointer, which the host loads before use. A short queue absorbs events that arrive while an entry is still being written. A pulse marks each entry once both of its words are stored. When a message error is enabled at high priority, the block also raises a halt output that freezes the protocol engine until the host acknowledges that error.

Top module: `irq_log_ctrl`

## Requirements
- R1: After reset, all enables, status bits, the halt, both standard outputs, the overflow flag and the list pointer are zero, and no memory write is requested.
- R2: A pulse on `hpEvt[i]` (i = 8 data overrun, 7 illogical command, 6 bus-control handover received, 5 subsystem fail, 4 self-test done, 3 self-test fail, 2 end of block list, 1 message error) sets `hpStatus[i]` at the next clock edge, whatever the enables hold.
- R3: A host write with `regSel` = 1 clears every status bit written as 1 and leaves bits written as 0 unchanged; an event arriving in the same cycle as the clear of its bit leaves the bit set.
- R4: `hpIrq` is high exactly while some `hpStatus` bit and the matching bit of the high-priority enable register (written with `regSel` = 0) are both 1.
- R5: A standard trigger sets `hpStatus[0]` only when high-priority enable bit 0 is 1.
- R6: `stdIrqLevel` rises the cycle after a standard trigger and stays high until the host writes 1 to status bit 0.
- R7: When `hpEvt[1]` pulses while high-priority enable bit 1 is 1, `engineHalt` rises at the next edge and stays high, whatever other events arrive, until the host writes 1 to status bit 1.
- R8: A standard trigger occurs in a cycle where `stdEvt` (bit 5 illegal broadcast, 4 illegal command, 3 poll match, 2 retry exhausted, 1 message error, 0 block notify) shares a 1 with the standard enable register (written with `regSel` = 2), or where `forceLog` is high and `stdEvt` is non-zero; any other `stdEvt` pattern changes no output.
- R9: Each logged event writes two words, each held on the write port until `memWrAck`: first the flag word (`stdEvt` in bits 5:0, upper bits zero) at the list pointer, then `ctxWord` at the pointer plus one.
- R10: At the edge that accepts the second word, the list pointer becomes the entry's base address plus 2, and `stdIrqPulse` is high for exactly the following cycle.
- R11: Up to two triggers wait while an entry is being written; a trigger that finds both places taken is dropped and sets `logOverflow`, which stays set until reset.
- R12: A host write with `regSel` = 3 loads the list pointer from `regWrData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hpEvt | input | 8 | High-priority event pulses, bits 8:1 |
| stdEvt | input | 6 | Standard event flags |
| forceLog | input | 1 | Log this cycle's standard flags regardless of the enable register |
| ctxWord | input | 16 | Command or descriptor address stored as the second entry word |
| regWrEn | input | 1 | Host register write strobe |
| regSel | input | 2 | Register select: 0 high enable, 1 status clear, 2 standard enable, 3 list pointer |
| regWrData | input | 16 | Host write data |
| memWrAck | input | 1 | Memory accepts the current word |
| memWrReq | output | 1 | Memory write request |
| memWrAddr | output | 16 | Memory write address |
| memWrData | output | 16 | Memory write data |
| hpIrq | output | 1 | High-priority interrupt level |
| stdIrqLevel | output | 1 | Standard interrupt level |
| stdIrqPulse | output | 1 | One-cycle pulse per completed log entry |
| engineHalt | output | 1 | Freeze request to the protocol engine |
| hpStatus | output | 9 | High-priority status bits |
| logPtr | output | 16 | Current list pointer |
| logOverflow | output | 1 | Sticky queue overflow flag |

## Verification
High-priority events are first raised with their enables off and then turned on one bit at a time. This separates pending status from the interrupt output and shows that a clear colliding with a new event keeps the bit set. Standard flags are driven disabled, enabled and forced, which separates the enable match from the override. The log is exercised with a memory that accepts at once and then with one that stalls at random. A four-cycle burst fills the queue and overflows it, and a long stretch of random traffic, register writes and halt episodes is compared cycle by cycle with a queue-based model.

// File: rtl/irq_log_pkg.sv
package irq_log_pkg;

  localparam int HP_W          = 9;
  localparam int STD_W         = 6;
  localparam int WORD_W        = 16;
  localparam int HP_STD_BIT    = 0;
  localparam int HP_MSGERR_BIT = 1;

  typedef enum logic [1:0] {
    SEL_HP_EN  = 2'd0,
    SEL_HP_CLR = 2'd1,
    SEL_STD_EN = 2'd2,
    SEL_PTR    = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    LOG_IDLE  = 2'd0,
    LOG_FLAGS = 2'd1,
    LOG_CTX   = 2'd2
  } logState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic secondWord;
    logic entryDone;
    logic ptrLoad;
  } logStrobe_t;

  typedef struct packed {
    logic [STD_W-1:0]  flags;
    logic [WORD_W-1:0] ctx;
  } logEntry_t;

endpackage

// File: rtl/irq_log_control.sv
module irq_log_control
  import irq_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HP_W-1:1]  hpEvt,
  input  logic [STD_W-1:0] stdEvt,
  input  logic             forceLog,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [HP_W-1:0]  regWrBits,
  input  logic             fifoEmpty,
  input  logic             memWrAck,
  output logStrobe_t       strb,
  output logic [HP_W-1:0]  hpStatus,
  output logic             hpIrq,
  output logic             stdIrqLevel,
  output logic             stdIrqPulse,
  output logic             engineHalt,
  output logic             memWrReq
);

  logic [HP_W-1:0]  hpEnQ;
  logic [HP_W-1:0]  statusQ;
  logic [HP_W-1:0]  statusSet;
  logic [HP_W-1:0]  statusClr;
  logic [STD_W-1:0] stdEnQ;
  logic             stdTrig;
  logic             wrHpEn;
  logic             wrClr;
  logic             wrStdEn;
  logic             wrPtr;
  logic             levelQ;
  logic             haltQ;
  logic             pulseQ;
  logState_e        stateQ;
  logState_e        stateD;

  always_comb begin
    wrHpEn    = regWrEn && (regSel == SEL_HP_EN);
    wrClr     = regWrEn && (regSel == SEL_HP_CLR);
    wrStdEn   = regWrEn && (regSel == SEL_STD_EN);
    wrPtr     = regWrEn && (regSel == SEL_PTR);
    stdTrig   = (|(stdEvt & stdEnQ)) || (forceLog && (|stdEvt));
    statusClr = wrClr ? regWrBits : '0;
    statusSet = {hpEvt, stdTrig && hpEnQ[HP_STD_BIT]};
  end

  // log writer sequencing
  always_comb begin
    stateD         = stateQ;
    strb           = '0;
    strb.push      = stdTrig;
    strb.ptrLoad   = wrPtr;
    unique case (stateQ)
      LOG_IDLE: begin
        if (!fifoEmpty) begin
          strb.pop = 1'b1;
          stateD   = LOG_FLAGS;
        end
      end
      LOG_FLAGS: begin
        if (memWrAck) stateD = LOG_CTX;
      end
      LOG_CTX: begin
        strb.secondWord = 1'b1;
        if (memWrAck) begin
          strb.entryDone = 1'b1;
          stateD         = LOG_IDLE;
        end
      end
      default: stateD = LOG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= LOG_IDLE;
      hpEnQ   <= '0;
      stdEnQ  <= '0;
      statusQ <= '0;
      levelQ  <= 1'b0;
      haltQ   <= 1'b0;
      pulseQ  <= 1'b0;
    end else begin
      stateQ  <= stateD;
      if (wrHpEn)  hpEnQ  <= regWrBits;
      if (wrStdEn) stdEnQ <= regWrBits[STD_W-1:0];
      statusQ <= (statusQ & ~statusClr) | statusSet;
      if (stdTrig)                     levelQ <= 1'b1;
      else if (statusClr[HP_STD_BIT])  levelQ <= 1'b0;
      if (hpEvt[HP_MSGERR_BIT] && hpEnQ[HP_MSGERR_BIT]) haltQ <= 1'b1;
      else if (statusClr[HP_MSGERR_BIT])                haltQ <= 1'b0;
      pulseQ  <= strb.entryDone;
    end
  end

  assign hpStatus    = statusQ;
  assign hpIrq       = |(statusQ & hpEnQ);
  assign stdIrqLevel = levelQ;
  assign stdIrqPulse = pulseQ;
  assign engineHalt  = haltQ;
  assign memWrReq    = (stateQ != LOG_IDLE);

  // R2: an event pulse is recorded at the next edge
  a_r2_event_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (|hpEvt) |=> ((hpStatus[HP_W-1:1] & $past(hpEvt)) == $past(hpEvt)));

  // R5: status bit 0 never stands without the standard level
  a_r5_status0_has_level: assert property (@(posedge clk) disable iff (!rst_n)
    hpStatus[HP_STD_BIT] |-> stdIrqLevel);

  // R7: halt holds until the message-error bit is acknowledged
  a_r7_halt_held: assert property (@(posedge clk) disable iff (!rst_n)
    (engineHalt && !statusClr[HP_MSGERR_BIT]) |=> engineHalt);

  a_r7_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (hpEvt[HP_MSGERR_BIT] && hpEnQ[HP_MSGERR_BIT]) |=> engineHalt);

  // R9: a request is held until memory accepts it
  a_r9_req_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrReq && !memWrAck) |=> memWrReq);

  // R10: the entry pulse lasts one cycle
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    stdIrqPulse |=> !stdIrqPulse);

endmodule

// File: rtl/irq_log_datapath.sv
module irq_log_datapath
  import irq_log_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logStrobe_t        strb,
  input  logic [STD_W-1:0]  stdEvt,
  input  logic [WORD_W-1:0] ctxWord,
  input  logic [ADDR_W-1:0] ptrWrData,
  output logic              fifoEmpty,
  output logic              logOverflow,
  output logic [ADDR_W-1:0] logPtr,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData
);

  localparam int IDX_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int PAD_W = WORD_W - STD_W;

  logEntry_t [FIFO_DEPTH-1:0] slotBus;
  logic [IDX_W-1:0]  wrIdxQ;
  logic [IDX_W-1:0]  rdIdxQ;
  logic [CNT_W-1:0]  countQ;
  logic              fifoFull;
  logic              doPush;
  logEntry_t         curQ;
  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] ptrQ;
  logic              ovfQ;

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(FIFO_DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  assign fifoFull  = (countQ == CNT_W'(FIFO_DEPTH));
  assign fifoEmpty = (countQ == '0);
  assign doPush    = strb.push && (!fifoFull || strb.pop);

  for (genvar g = 0; g < FIFO_DEPTH; g++) begin : gSlot
    logEntry_t slotQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slotQ <= '0;
      else if (doPush && (wrIdxQ == IDX_W'(g)))    slotQ <= '{flags: stdEvt, ctx: ctxWord};
    end
    assign slotBus[g] = slotQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrIdxQ <= '0;
      rdIdxQ <= '0;
      countQ <= '0;
      curQ   <= '0;
      baseQ  <= '0;
      ptrQ   <= '0;
      ovfQ   <= 1'b0;
    end else begin
      if (doPush)   wrIdxQ <= nextIdx(wrIdxQ);
      if (strb.pop) begin
        rdIdxQ <= nextIdx(rdIdxQ);
        curQ   <= slotBus[rdIdxQ];
        baseQ  <= ptrQ;
      end
      countQ <= countQ + CNT_W'(doPush) - CNT_W'(strb.pop);
      if (strb.push && fifoFull && !strb.pop) ovfQ <= 1'b1;
      if (strb.ptrLoad)        ptrQ <= ptrWrData;
      else if (strb.entryDone) ptrQ <= baseQ + ADDR_W'(2);
    end
  end

  assign logOverflow = ovfQ;
  assign logPtr      = ptrQ;
  assign memWrAddr   = strb.secondWord ? baseQ + ADDR_W'(1) : baseQ;
  assign memWrData   = strb.secondWord ? curQ.ctx : {{PAD_W{1'b0}}, curQ.flags};

  // R11: queue occupancy never exceeds its depth
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    countQ <= CNT_W'(FIFO_DEPTH));

  // R11: overflow flag is sticky
  a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    logOverflow |=> logOverflow);

  // R10: pointer steps past the second word of the finished entry
  a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.entryDone && !strb.ptrLoad) |=> (logPtr == $past(memWrAddr) + ADDR_W'(1)));

endmodule

// File: rtl/irq_log_ctrl.sv
module irq_log_ctrl
  import irq_log_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HP_W-1:1]   hpEvt,
  input  logic [STD_W-1:0]  stdEvt,
  input  logic              forceLog,
  input  logic [WORD_W-1:0] ctxWord,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              memWrAck,
  output logic              memWrReq,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic              hpIrq,
  output logic              stdIrqLevel,
  output logic              stdIrqPulse,
  output logic              engineHalt,
  output logic [HP_W-1:0]   hpStatus,
  output logic [ADDR_W-1:0] logPtr,
  output logic              logOverflow
);

  logStrobe_t strb;
  logic       fifoEmpty;

  irq_log_control control_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hpEvt       (hpEvt),
    .stdEvt      (stdEvt),
    .forceLog    (forceLog),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .regWrBits   (regWrData[HP_W-1:0]),
    .fifoEmpty   (fifoEmpty),
    .memWrAck    (memWrAck),
    .strb        (strb),
    .hpStatus    (hpStatus),
    .hpIrq       (hpIrq),
    .stdIrqLevel (stdIrqLevel),
    .stdIrqPulse (stdIrqPulse),
    .engineHalt  (engineHalt),
    .memWrReq    (memWrReq)
  );

  irq_log_datapath #(
    .ADDR_W     (ADDR_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) datapath_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .stdEvt      (stdEvt),
    .ctxWord     (ctxWord),
    .ptrWrData   (regWrData[ADDR_W-1:0]),
    .fifoEmpty   (fifoEmpty),
    .logOverflow (logOverflow),
    .logPtr      (logPtr),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData)
  );

endmodule

// File: tb/irq_log_ctrl_tb_top.sv
module irq_log_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:1]  hpEvt = '0;
  logic [5:0]  stdEvt = '0;
  logic        forceLog = 1'b0;
  logic [15:0] ctxWord = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = '0;
  logic [15:0] regWrData = '0;
  logic        memWrAck = 1'b0;
  logic        memWrReq;
  logic [15:0] memWrAddr;
  logic [15:0] memWrData;
  logic        hpIrq, stdIrqLevel, stdIrqPulse, engineHalt, logOverflow;
  logic [8:0]  hpStatus;
  logic [15:0] logPtr;

  irq_log_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .hpEvt(hpEvt), .stdEvt(stdEvt), .forceLog(forceLog),
    .ctxWord(ctxWord), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .memWrAck(memWrAck), .memWrReq(memWrReq), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .hpIrq(hpIrq), .stdIrqLevel(stdIrqLevel), .stdIrqPulse(stdIrqPulse),
    .engineHalt(engineHalt), .hpStatus(hpStatus), .logPtr(logPtr), .logOverflow(logOverflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int pulseCount = 0;
  bit finished = 1'b0;
  bit ackSlow = 1'b0;
  logic [15:0] mem [0:255];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- reference model ----------------
  typedef struct { logic [5:0] f; logic [15:0] c; } ent_t;
  ent_t        q[$];
  int          mState;
  logic [15:0] mPtr, mBase, curC;
  logic [5:0]  curF, mStdEn;
  logic [8:0]  mStat, mHpEn;
  bit          mLvl, mHalt, mPulse, mOvf;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      mState = 0; mPtr = '0; mBase = '0; curC = '0; curF = '0; mStdEn = '0;
      mStat = '0; mHpEn = '0; mLvl = 0; mHalt = 0; mPulse = 0; mOvf = 0;
    end else begin
      bit trig;
      bit adv;
      logic [8:0] clr;
      logic [8:0] setv;
      ent_t e;
      trig = (|(stdEvt & mStdEn)) || (forceLog && (|stdEvt));
      clr  = (regWrEn && regSel == 2'd1) ? regWrData[8:0] : 9'h0;
      setv = {hpEvt, trig && mHpEn[0]};
      if (hpEvt[1] && mHpEn[1]) mHalt = 1; else if (clr[1]) mHalt = 0;
      if (trig) mLvl = 1; else if (clr[0]) mLvl = 0;
      mStat  = (mStat & ~clr) | setv;
      mPulse = 0;
      adv    = 0;
      if (mState == 0) begin
        if (q.size() != 0) begin
          e = q.pop_front(); curF = e.f; curC = e.c; mBase = mPtr; mState = 1;
        end
      end else if (mState == 1) begin
        if (memWrAck) mState = 2;
      end else begin
        if (memWrAck) begin mPulse = 1; adv = 1; mState = 0; end
      end
      if (trig) begin
        if (q.size() < 2) begin e.f = stdEvt; e.c = ctxWord; q.push_back(e); end
        else mOvf = 1;
      end
      if (regWrEn && regSel == 2'd3) mPtr = regWrData;
      else if (adv)                  mPtr = mBase + 16'd2;
      if (regWrEn && regSel == 2'd0) mHpEn  = regWrData[8:0];
      if (regWrEn && regSel == 2'd2) mStdEn = regWrData[5:0];
    end
  end

  // memory responder and capture
  always @(negedge clk) memWrAck = memWrReq && (!ackSlow || ($urandom_range(0, 1) == 1));
  always @(posedge clk) if (rst_n && memWrReq && memWrAck) mem[memWrAddr[7:0]] <= memWrData;
  always @(negedge clk) if (stdIrqPulse) pulseCount++;

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 hpIrq", {31'd0, hpIrq}, {31'd0, |(mStat & mHpEn)});
      chk("R2 hpStatus", {23'd0, hpStatus}, {23'd0, mStat});
      chk("R6 stdIrqLevel", {31'd0, stdIrqLevel}, {31'd0, mLvl});
      chk("R10 stdIrqPulse", {31'd0, stdIrqPulse}, {31'd0, mPulse});
      chk("R7 engineHalt", {31'd0, engineHalt}, {31'd0, mHalt});
      chk("R10 logPtr", {16'd0, logPtr}, {16'd0, mPtr});
      chk("R11 logOverflow", {31'd0, logOverflow}, {31'd0, mOvf});
      chk("R9 memWrReq", {31'd0, memWrReq}, {31'd0, mState != 0});
      if (mState != 0) begin
        chk("R9 memWrAddr", {16'd0, memWrAddr}, {16'd0, (mState == 1) ? mBase : mBase + 16'd1});
        chk("R9 memWrData", {16'd0, memWrData}, {16'd0, (mState == 1) ? {10'd0, curF} : curC});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic evt(input logic [8:1] h, input logic [5:0] s, input bit f, input logic [15:0] c);
    hpEvt = h; stdEvt = s; forceLog = f; ctxWord = c;
    @(negedge clk);
    hpEvt = '0; stdEvt = '0; forceLog = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 hpStatus", {23'd0, hpStatus}, 32'd0);
    chk("R1 outputs", {27'd0, hpIrq, stdIrqLevel, stdIrqPulse, engineHalt, logOverflow}, 32'd0);
    chk("R1 logPtr", {16'd0, logPtr}, 32'd0);
    chk("R1 memWrReq", {31'd0, memWrReq}, 32'd0);

    // R2 / R4: pending status without enable
    evt(8'b1000_0100, 6'd0, 1'b0, 16'd0);
    chk("R2 status bits 8 and 3", {23'd0, hpStatus}, 32'h108);
    chk("R4 no irq without enable", {31'd0, hpIrq}, 32'd0);
    wr(2'd0, 16'h0008);
    chk("R4 irq with enable bit 3", {31'd0, hpIrq}, 32'd1);
    // R3 write-one-to-clear
    wr(2'd1, 16'h0100);
    chk("R3 clear bit 8 only", {23'd0, hpStatus}, 32'h008);
    wr(2'd1, 16'h0000);
    chk("R3 zero write keeps bits", {23'd0, hpStatus}, 32'h008);
    regWrEn = 1'b1; regSel = 2'd1; regWrData = 16'h0108; hpEvt = 8'b1000_0000;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; hpEvt = '0;
    chk("R3 set wins over clear", {23'd0, hpStatus}, 32'h100);
    wr(2'd1, 16'h01FF);
    chk("R4 irq drops after clear", {31'd0, hpIrq}, 32'd0);

    // R7 halt on enabled message error
    wr(2'd0, 16'h0002);
    evt(8'b0000_0001, 6'd0, 1'b0, 16'd0);
    chk("R7 halt raised", {31'd0, engineHalt}, 32'd1);
    evt(8'b0011_0000, 6'd0, 1'b0, 16'd0);
    idle(3);
    wr(2'd1, 16'h0004);
    chk("R7 halt held after other clear", {31'd0, engineHalt}, 32'd1);
    wr(2'd1, 16'h0002);
    chk("R7 halt released", {31'd0, engineHalt}, 32'd0);
    wr(2'd0, 16'h0000);
    evt(8'b0000_0001, 6'd0, 1'b0, 16'd0);
    chk("R7 no halt when disabled", {31'd0, engineHalt}, 32'd0);
    wr(2'd1, 16'h01FF);

    // R8 standard trigger qualification
    wr(2'd2, 16'h0004);
    wr(2'd0, 16'h0001);
    evt(8'd0, 6'b001000, 1'b0, 16'hAAAA);
    idle(6);
    chk("R8 disabled flag ignored level", {31'd0, stdIrqLevel}, 32'd0);
    chk("R8 disabled flag ignored ptr", {16'd0, logPtr}, 32'd0);
    evt(8'd0, 6'b001000, 1'b1, 16'h1234);
    idle(8);
    chk("R8 forced log level", {31'd0, stdIrqLevel}, 32'd1);
    chk("R5 status bit0 with enable", {23'd0, hpStatus}, 32'h001);
    chk("R10 ptr after one entry", {16'd0, logPtr}, 32'd2);
    chk("R9 flag word", {16'd0, mem[0]}, 32'h0008);
    chk("R9 context word", {16'd0, mem[1]}, 32'h1234);
    wr(2'd1, 16'h0001);
    chk("R6 level cleared", {31'd0, stdIrqLevel}, 32'd0);
    wr(2'd0, 16'h0000);
    evt(8'd0, 6'b000100, 1'b0, 16'h5678);
    idle(8);
    chk("R5 status bit0 stays clear", {23'd0, hpStatus}, 32'h000);
    chk("R6 level without status", {31'd0, stdIrqLevel}, 32'd1);
    chk("R10 ptr after two entries", {16'd0, logPtr}, 32'd4);
    chk("R9 second entry context", {16'd0, mem[3]}, 32'h5678);
    wr(2'd1, 16'h0001);

    // R12 pointer load, R11 overflow with stalling memory
    wr(2'd3, 16'h0040);
    chk("R12 pointer loaded", {16'd0, logPtr}, 32'h40);
    ackSlow = 1'b1;
    pulseCount = 0;
    for (int i = 0; i < 4; i++) evt(8'd0, 6'b000100, 1'b0, 16'(16'h0100 + i));
    chk("R11 overflow raised", {31'd0, logOverflow}, 32'd1);
    idle(80);
    chk("R11 three entries stored", {16'd0, logPtr}, 32'h46);
    chk("R10 one pulse per entry", pulseCount, 32'd3);
    chk("R11 overflow sticky", {31'd0, logOverflow}, 32'd1);
    chk("R9 last kept entry", {16'd0, mem[8'h45]}, 32'h0102);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      ackSlow   = (n / 500) % 2 == 1;
      hpEvt     = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'd0;
      stdEvt    = ($urandom_range(0, 2) == 0) ? 6'($urandom) : 6'd0;
      forceLog  = ($urandom_range(0, 5) == 0);
      ctxWord   = 16'($urandom);
      regWrEn   = ($urandom_range(0, 9) == 0);
      regSel    = 2'($urandom);
      regWrData = 16'($urandom);
      @(negedge clk);
    end
    hpEvt = '0; stdEvt = '0; forceLog = 1'b0; regWrEn = 1'b0;
    idle(40);
    finishRun();
  end

endmodule